// File: doc/BRIEF.md
# Bus Controller Receive-Message Sequencer

This block runs one controller-to-terminal receive transfer on a command/response serial avionics bus. A host places a terminal address, a subaddress, a 5-bit word-count field and an inter-message gap setting on its inputs and pulses `start`. The block then does the following in order:

- It assembles the command word and offers it to a word serializer.
- It streams the data words that follow the command out of an external buffer, with no idle cycle between words.
- It waits for the serializer to go quiet. It then opens a timing window for the terminal's reply.
- It captures the reply word from a word deserializer and checks it.

On completion the block pulses `done` and latches a result vector and the reply word. A new message may be accepted at once. Its command word is held back until the programmed quiet time since the previous completion has passed.

All timing is counted in clock cycles, derived from a cycles-per-microsecond parameter. A reply must start no earlier than the minimum and no later than the maximum response time after the last transmitted word. Otherwise the reply is flagged as early or as a timeout. The block covers only the receive direction for a single addressed terminal.

Top module: `bcs_msg_seq`

## Requirements
- R1: The command word offered first has the terminal address in bits 15:11, a zero direction bit (receive) in bit 10, the subaddress in bits 9:5 and the word-count field in bits 4:0. It is offered with `enc_cmd_sync` high.
- R2: A word-count field of N in 1..31 sends N data words. A field of 0 sends 32 data words.
- R3: Data words are read from buffer addresses 0, 1, ... in ascending order and offered with `enc_cmd_sync` low. `enc_valid` stays high from the command word until the last data word is taken, and an offered word holds steady until `enc_ready`.
- R4: Let t be the number of cycles from the first cycle `enc_idle` is high after the last word to the cycle `dec_start` is high. t from RESP_MIN to RESP_MAX (4 and 12 µs) is an in-time reply. If there is no `dec_start` up to t = RESP_MAX, timeout (`res_flags` bit 0) is set and `done` is seen RESP_MAX+1 cycles after that first idle cycle.
- R5: The reply is checked when `dec_valid` arrives. Bit 1 is set if `dec_word[15:11]` differs from the commanded address. Bit 2 is set on `dec_par_err`. Bit 3 is set if `dec_cmd_sync` is low. All-zero flags mean success.
- R6: `res_flags` and `rsp_word` keep their values after `done` until the next accepted start, which clears them.
- R7: `busy` rises the cycle after an accepted start and falls with the `done` pulse. A start seen while busy is ignored: no extra command word is sent and the latched fields stay unchanged.
- R8: After a completion, the next command word is not offered until G = clamp(`gap_us`, 4, 12) × CLK_PER_US cycles after the `done` cycle. G uses the finished message's `gap_us`. After reset the first message is not delayed.
- R9: If `dec_valid` does not follow `dec_start` within WORD_MAX (24 µs) cycles, timeout is set.
- R10: A reply start with t < RESP_MIN sets bit 4 (early), and the reply word is still checked.
- R11: After reset, `busy`, `done`, `enc_valid` and `res_flags` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a message (ignored while busy) |
| rt_addr | input | 5 | Terminal address |
| sub_addr | input | 5 | Subaddress |
| wc_field | input | 5 | Word-count field, 0 means 32 |
| gap_us | input | 4 | Quiet time after this message, µs, clamped to 4..12 |
| busy | output | 1 | Message in progress |
| done | output | 1 | One-cycle completion pulse |
| res_flags | output | 5 | {early, sync, parity, address, timeout} |
| rsp_word | output | 16 | Captured reply word |
| buf_addr | output | 5 | Data buffer read address |
| buf_data | input | 16 | Data buffer read data (same cycle) |
| enc_valid | output | 1 | Word offered to serializer |
| enc_cmd_sync | output | 1 | 1: command sync, 0: data sync |
| enc_word | output | 16 | Word offered |
| enc_ready | input | 1 | Serializer takes the offered word |
| enc_idle | input | 1 | Serializer has nothing in flight |
| dec_start | input | 1 | Deserializer saw a sync begin |
| dec_valid | input | 1 | Deserializer word complete |
| dec_cmd_sync | input | 1 | Received word had command/status sync |
| dec_par_err | input | 1 | Received word failed parity |
| dec_word | input | 16 | Received word |

## Verification
The embedded properties check on every cycle that offered words stay stable until taken and that a command word always carries the receive direction and the latched address. They also check that the buffer address never reaches the commanded count, that the quiet time since the last completion is respected, that busy rises only from a start, and that a clean result matches the commanded address. Only the bench scenarios can show the exact word sequence, the gapless stream, and the boundaries of the reply window (t equal to RESP_MIN−1, RESP_MIN and RESP_MAX). The same holds for the exact cycle of a timeout, the 32-word encoding, the clamping of the gap setting, the latching of results, and the rejection of a start that arrives mid-message.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

    localparam int FLD_W  = 5;
    localparam int WORD_W = 16;
    localparam int CNT_W  = 6;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CMD,
        S_DATA,
        S_DRAIN,
        S_RWAIT,
        S_RWORD
    } seq_state_e;

    typedef struct packed {
        logic [FLD_W-1:0] rt;
        logic [FLD_W-1:0] sa;
        logic [FLD_W-1:0] wc;
        logic [3:0]       gap;
    } msg_req_t;

    // bit order: [4] early, [3] sync, [2] parity, [1] address, [0] timeout
    typedef struct packed {
        logic early;
        logic sync_bad;
        logic par_bad;
        logic addr_bad;
        logic timeout;
    } res_flags_t;

    function automatic logic [WORD_W-1:0] build_cmd(
        input logic [FLD_W-1:0] rt, input logic tx,
        input logic [FLD_W-1:0] sa, input logic [FLD_W-1:0] wc);
        return {rt, tx, sa, wc};
    endfunction

    function automatic logic [CNT_W-1:0] words_of(input logic [FLD_W-1:0] wc);
        return (wc == '0) ? CNT_W'(32) : {1'b0, wc};
    endfunction

    function automatic int clamp_us(input logic [3:0] g, input int lo, input int hi);
        int v;
        v = int'(g);
        if (v < lo) v = lo;
        if (v > hi) v = hi;
        return v;
    endfunction

endpackage

// File: rtl/bcs_word_src.sv
module bcs_word_src
    import bcs_pkg::*;
(
    input  logic               sel_cmd,
    input  msg_req_t           req,
    input  logic [CNT_W-1:0]   idx,
    input  logic [WORD_W-1:0]  buf_data,
    output logic [WORD_W-1:0]  word,
    output logic               cmd_sync,
    output logic [FLD_W-1:0]   buf_addr
);
    always_comb begin
        buf_addr = idx[FLD_W-1:0];
        cmd_sync = sel_cmd;
        if (sel_cmd)
            word = build_cmd(req.rt, 1'b0, req.sa, req.wc);
        else
            word = buf_data;
    end
endmodule

// File: rtl/bcs_gap_timer.sv
module bcs_gap_timer #(
    parameter int GAP_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [GAP_W-1:0] load_val,
    output logic             ok
);
    logic [GAP_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign ok = (cnt == '0);

    assert_gap_load_R8: assert property (@(posedge clk) disable iff (rst)
        load && (load_val != '0) |=> !ok);
endmodule

// File: rtl/bcs_resp_check.sv
module bcs_resp_check
    import bcs_pkg::*;
(
    input  logic [FLD_W-1:0]  expect_rt,
    input  logic [WORD_W-1:0] rx_word,
    input  logic              rx_cmd_sync,
    input  logic              rx_par_err,
    output logic              addr_bad,
    output logic              par_bad,
    output logic              sync_bad
);
    always_comb begin
        addr_bad = (rx_word[WORD_W-1 -: FLD_W] != expect_rt);
        par_bad  = rx_par_err;
        sync_bad = !rx_cmd_sync;
    end
endmodule

// File: rtl/bcs_msg_seq.sv
module bcs_msg_seq
    import bcs_pkg::*;
#(
    parameter int CLK_PER_US  = 8,
    parameter int RESP_MIN_US = 4,
    parameter int RESP_MAX_US = 12,
    parameter int WORD_TO_US  = 24,
    parameter int GAP_MIN_US  = 4,
    parameter int GAP_MAX_US  = 12
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [4:0]  rt_addr,
    input  logic [4:0]  sub_addr,
    input  logic [4:0]  wc_field,
    input  logic [3:0]  gap_us,
    output logic        busy,
    output logic        done,
    output logic [4:0]  res_flags,
    output logic [15:0] rsp_word,
    output logic [4:0]  buf_addr,
    input  logic [15:0] buf_data,
    output logic        enc_valid,
    output logic        enc_cmd_sync,
    output logic [15:0] enc_word,
    input  logic        enc_ready,
    input  logic        enc_idle,
    input  logic        dec_start,
    input  logic        dec_valid,
    input  logic        dec_cmd_sync,
    input  logic        dec_par_err,
    input  logic [15:0] dec_word
);
    localparam int RESP_MIN = RESP_MIN_US * CLK_PER_US;
    localparam int RESP_MAX = RESP_MAX_US * CLK_PER_US;
    localparam int WORD_MAX = WORD_TO_US * CLK_PER_US;
    localparam int TMR_TOP  = (WORD_MAX > RESP_MAX) ? WORD_MAX : RESP_MAX;
    localparam int TW       = $clog2(TMR_TOP + 1);
    localparam int GAP_TOP  = GAP_MAX_US * CLK_PER_US;
    localparam int GAP_W    = $clog2(GAP_TOP + 1);
    localparam logic [TW-1:0] RESP_MIN_C = TW'(RESP_MIN);
    localparam logic [TW-1:0] RESP_MAX_C = TW'(RESP_MAX);
    localparam logic [TW-1:0] WORD_MAX_C = TW'(WORD_MAX);

    seq_state_e        state;
    msg_req_t          req_q;
    logic [CNT_W-1:0]  idx;
    logic [TW-1:0]     tmr;
    logic              early_q;
    res_flags_t        flags_q;

    logic              gap_ok;
    logic              accept;
    logic              last_word;
    logic              fin;
    logic              fin_timeout;
    logic [GAP_W-1:0]  gap_cycles;
    logic              chk_addr, chk_par, chk_sync;
    logic [CNT_W-1:0]  nwords;

    bcs_word_src u_src (
        .sel_cmd  (state == S_CMD),
        .req      (req_q),
        .idx      (idx),
        .buf_data (buf_data),
        .word     (enc_word),
        .cmd_sync (enc_cmd_sync),
        .buf_addr (buf_addr)
    );

    bcs_resp_check u_chk (
        .expect_rt   (req_q.rt),
        .rx_word     (dec_word),
        .rx_cmd_sync (dec_cmd_sync),
        .rx_par_err  (dec_par_err),
        .addr_bad    (chk_addr),
        .par_bad     (chk_par),
        .sync_bad    (chk_sync)
    );

    bcs_gap_timer #(.GAP_W(GAP_W)) u_gap (
        .clk      (clk),
        .rst      (rst),
        .load     (fin),
        .load_val (gap_cycles),
        .ok       (gap_ok)
    );

    always_comb begin
        nwords      = words_of(req_q.wc);
        enc_valid   = ((state == S_CMD) && gap_ok) || (state == S_DATA);
        accept      = enc_valid && enc_ready;
        last_word   = (idx == nwords - 1'b1);
        gap_cycles  = GAP_W'(clamp_us(req_q.gap, GAP_MIN_US, GAP_MAX_US) * CLK_PER_US);
        fin_timeout = ((state == S_RWAIT) && !dec_start && (tmr >= RESP_MAX_C)) ||
                      ((state == S_RWORD) && !dec_valid && (tmr >= WORD_MAX_C));
        fin         = fin_timeout || ((state == S_RWORD) && dec_valid);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_IDLE;
            req_q   <= '0;
            idx     <= '0;
            tmr     <= '0;
            early_q <= 1'b0;
            flags_q <= '0;
            rsp_word <= '0;
            busy    <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                S_IDLE: begin
                    if (start) begin
                        req_q    <= '{rt: rt_addr, sa: sub_addr, wc: wc_field, gap: gap_us};
                        busy     <= 1'b1;
                        flags_q  <= '0;
                        rsp_word <= '0;
                        early_q  <= 1'b0;
                        idx      <= '0;
                        state    <= S_CMD;
                    end
                end
                S_CMD: begin
                    if (accept) begin
                        idx   <= '0;
                        state <= S_DATA;
                    end
                end
                S_DATA: begin
                    if (accept) begin
                        if (last_word)
                            state <= S_DRAIN;
                        else
                            idx <= idx + 1'b1;
                    end
                end
                S_DRAIN: begin
                    if (enc_idle) begin
                        tmr   <= TW'(1);
                        state <= S_RWAIT;
                    end
                end
                S_RWAIT: begin
                    if (dec_start) begin
                        early_q <= (tmr < RESP_MIN_C);
                        tmr     <= '0;
                        state   <= S_RWORD;
                    end else if (!fin_timeout) begin
                        tmr <= tmr + 1'b1;
                    end
                end
                S_RWORD: begin
                    if (dec_valid) begin
                        flags_q  <= '{early: early_q, sync_bad: chk_sync,
                                      par_bad: chk_par, addr_bad: chk_addr,
                                      timeout: 1'b0};
                        rsp_word <= dec_word;
                    end else if (!fin_timeout) begin
                        tmr <= tmr + 1'b1;
                    end
                end
                default: state <= S_IDLE;
            endcase

            if (fin_timeout)
                flags_q <= '{early: early_q, sync_bad: 1'b0, par_bad: 1'b0,
                             addr_bad: 1'b0, timeout: 1'b1};
            if (fin) begin
                done  <= 1'b1;
                busy  <= 1'b0;
                state <= S_IDLE;
            end
        end
    end

    assign res_flags = flags_q;

    // ---------------- checker state and properties ----------------
    logic [GAP_W-1:0] since_done;
    logic [GAP_W-1:0] gap_need;
    logic             seen_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_done <= '0;
            gap_need   <= '0;
            seen_done  <= 1'b0;
        end else if (done) begin
            since_done <= GAP_W'(1);
            gap_need   <= GAP_W'(clamp_us(req_q.gap, GAP_MIN_US, GAP_MAX_US) * CLK_PER_US);
            seen_done  <= 1'b1;
        end else if (since_done != GAP_W'(GAP_TOP)) begin
            since_done <= since_done + 1'b1;
        end
    end

    assert_cmd_receive_R1: assert property (@(posedge clk) disable iff (rst)
        enc_valid && enc_cmd_sync |-> (enc_word[10] == 1'b0) && (enc_word[15:11] == req_q.rt));

    assert_addr_in_range_R2: assert property (@(posedge clk) disable iff (rst)
        enc_valid && !enc_cmd_sync |-> {1'b0, buf_addr} < nwords);

    assert_offer_stable_R3: assert property (@(posedge clk) disable iff (rst)
        enc_valid && !enc_ready |=> enc_valid && $stable(enc_word) && $stable(enc_cmd_sync));

    assert_timeout_with_done_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(res_flags[0]) |-> done);

    assert_clean_addr_R5: assert property (@(posedge clk) disable iff (rst)
        done && (res_flags == 5'b0) |-> rsp_word[15:11] == req_q.rt);

    assert_busy_from_start_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

    assert_quiet_time_R8: assert property (@(posedge clk) disable iff (rst)
        enc_valid && enc_cmd_sync && seen_done |-> since_done >= gap_need);

endmodule

// File: tb/tb_bcs_msg_seq.sv
`timescale 1ns/1ps
module tb_bcs_msg_seq;
    localparam int CPU   = 8;
    localparam int RMIN  = 4 * CPU;
    localparam int RMAX  = 12 * CPU;
    localparam int WLEN  = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic        start = 0;
    logic [4:0]  rt_addr = 0, sub_addr = 0, wc_field = 0;
    logic [3:0]  gap_us = 0;
    logic        busy, done;
    logic [4:0]  res_flags;
    logic [15:0] rsp_word;
    logic [4:0]  buf_addr;
    logic [15:0] buf_data;
    logic        enc_valid, enc_cmd_sync;
    logic [15:0] enc_word;
    logic        enc_ready, enc_idle;
    logic        dec_start = 0, dec_valid = 0, dec_cmd_sync = 0, dec_par_err = 0;
    logic [15:0] dec_word = 0;

    logic [15:0] mem [32];
    assign buf_data = mem[buf_addr];

    bcs_msg_seq #(.CLK_PER_US(CPU)) dut (
        .clk(clk), .rst(rst), .start(start), .rt_addr(rt_addr), .sub_addr(sub_addr),
        .wc_field(wc_field), .gap_us(gap_us), .busy(busy), .done(done),
        .res_flags(res_flags), .rsp_word(rsp_word), .buf_addr(buf_addr),
        .buf_data(buf_data), .enc_valid(enc_valid), .enc_cmd_sync(enc_cmd_sync),
        .enc_word(enc_word), .enc_ready(enc_ready), .enc_idle(enc_idle),
        .dec_start(dec_start), .dec_valid(dec_valid), .dec_cmd_sync(dec_cmd_sync),
        .dec_par_err(dec_par_err), .dec_word(dec_word));

    // serializer model: takes a word when empty, busy for WLEN cycles
    int enc_cnt = 0;
    assign enc_ready = (enc_cnt == 0);
    assign enc_idle  = (enc_cnt == 0);
    always @(posedge clk) begin
        if (enc_valid && enc_ready) enc_cnt <= WLEN - 1;
        else if (enc_cnt > 0)       enc_cnt <= enc_cnt - 1;
    end

    // monitor at negedge: logs words about to be taken, counts stream holes
    logic [15:0] log_w [4096];
    logic        log_s [4096];
    int log_n = 0, holes = 0, exp_end = 0;
    bit streaming = 0;
    always @(negedge clk) begin
        if (streaming && !enc_valid) holes++;
        if (enc_valid && enc_ready) begin
            log_w[log_n] = enc_word;
            log_s[log_n] = enc_cmd_sync;
            log_n++;
            streaming = (log_n < exp_end);
        end
    end

    int n_chk = 0, n_bad = 0;
    int prev_gap = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int gap_cyc(input logic [3:0] g);
        int v = int'(g);
        if (v < 4) v = 4;
        if (v > 12) v = 12;
        return v * CPU;
    endfunction

    function automatic int nw(input logic [4:0] wc);
        return (wc == 0) ? 32 : int'(wc);
    endfunction

    // mode: 0 ok, 1 addr, 2 parity, 3 sync, 4 no reply, 5 word timeout, 6 start-while-busy
    // called at a negedge; chained=1 means right after a previous done
    task automatic run_msg(input logic [4:0] rt, input logic [4:0] sa, input logic [4:0] wc,
                           input logic [3:0] g, input int j, input int mode, input bit chained);
        int base, total, cnt, exp_flags;
        logic [15:0] sw;
        total = 1 + nw(wc);
        base = log_n;
        exp_end = base + total;
        for (int k = 0; k < 32; k++) mem[k] = 16'($urandom);
        rt_addr = rt; sub_addr = sa; wc_field = wc; gap_us = g; start = 1;
        cnt = 0;
        do begin
            @(negedge clk);
            if (cnt == 0) begin
                start = 0;
                chk(busy == 1, "R7 busy after start", busy, 1);
                chk(res_flags == 0, "R6 flags cleared by start", res_flags, 0);
            end
            cnt++;
        end while (!enc_valid && cnt < 1000);
        chk(cnt == (chained ? prev_gap : 1), "R8 command offer delay", cnt, chained ? prev_gap : 1);
        if (mode == 6) begin
            rt_addr = ~rt; wc_field = wc + 5'd3; start = 1;
            @(negedge clk);
            start = 0;
        end
        while (log_n < base + total) @(negedge clk);
        do @(negedge clk); while (!enc_idle);
        // stream content
        chk(log_w[base] == {rt, 1'b0, sa, wc} && log_s[base] == 1, "R1 command word",
            int'(log_w[base]), int'({rt, 1'b0, sa, wc}));
        for (int k = 0; k < nw(wc); k++)
            chk(log_w[base+1+k] == mem[k] && log_s[base+1+k] == 0, "R3 data word order",
                int'(log_w[base+1+k]), int'(mem[k]));
        chk(holes == 0, "R3 gapless stream", holes, 0);
        sw = {rt, 11'($urandom)};
        exp_flags = (j < RMIN) ? 16 : 0;
        if (mode == 4) begin
            cnt = 0;
            do begin @(negedge clk); cnt++; end while (!done && cnt < 1000);
            chk(cnt == RMAX + 1, "R4 timeout cycle", cnt, RMAX + 1);
            chk(res_flags == 1, "R4 timeout flag", res_flags, 1);
            chk(rsp_word == 0, "R4 no reply word", rsp_word, 0);
        end else begin
            repeat (j) @(negedge clk);
            dec_start = 1;
            @(negedge clk);
            dec_start = 0;
            if (mode == 5) begin
                cnt = 0;
                while (!done && cnt < 1000) begin @(negedge clk); cnt++; end
                chk(res_flags == (1 | exp_flags), "R9 reply word timeout", res_flags, 1 | exp_flags);
            end else begin
                repeat (3) @(negedge clk);
                dec_cmd_sync = (mode != 3);
                dec_par_err  = (mode == 2);
                if (mode == 1) sw[15:11] = rt ^ 5'h04;
                dec_word = sw; dec_valid = 1;
                @(negedge clk);
                dec_valid = 0;
                if (mode == 1) exp_flags |= 2;
                if (mode == 2) exp_flags |= 4;
                if (mode == 3) exp_flags |= 8;
                chk(done == 1, "R5 done on reply", done, 1);
                chk(res_flags == exp_flags, (j < RMIN) ? "R10 early flag" : "R5 reply check",
                    res_flags, exp_flags);
                chk(rsp_word == sw, "R6 reply captured", rsp_word, sw);
            end
        end
        chk(busy == 0, "R7 busy falls with done", busy, 0);
        if (mode == 6)
            chk(log_n == base + total, "R7 busy start ignored", log_n - base, total);
        prev_gap = gap_cyc(g);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int fl, rw;
        void'($urandom(32'd20240611));
        for (int k = 0; k < 32; k++) mem[k] = 0;
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(busy == 0 && done == 0, "R11 reset busy/done", {busy, done}, 0);
        chk(enc_valid == 0, "R11 reset enc_valid", enc_valid, 0);
        chk(res_flags == 0, "R11 reset flags", res_flags, 0);
        // directed corners
        run_msg(5'h07, 5'h03, 5'd0, 4'd5, RMIN, 0, 0);          // R2 32 words, window low edge
        run_msg(5'h11, 5'h1E, 5'd1, 4'd0, RMAX, 0, 1);          // window high edge, gap clamp low
        run_msg(5'h02, 5'h01, 5'd2, 4'd15, RMIN - 1, 0, 1);     // R10 early, gap clamp high
        run_msg(5'h1F, 5'h00, 5'd3, 4'd7, 0, 4, 1);             // R4 no reply
        fl = res_flags; rw = rsp_word;
        repeat (10) @(negedge clk);
        chk(res_flags == fl && rsp_word == rw, "R6 result held", res_flags, fl);
        repeat (200) @(negedge clk);
        run_msg(5'h0A, 5'h05, 5'd4, 4'd4, 50, 1, 0);            // addr mismatch
        run_msg(5'h0B, 5'h06, 5'd2, 4'd6, 60, 2, 1);            // parity
        run_msg(5'h0C, 5'h07, 5'd2, 4'd8, 40, 3, 1);            // sync type
        run_msg(5'h0D, 5'h08, 5'd1, 4'd9, 45, 5, 1);            // R9 word timeout
        run_msg(5'h0E, 5'h09, 5'd6, 4'd4, 70, 6, 1);            // R7 start while busy
        // constrained random, chained back to back
        for (int i = 0; i < 16; i++) begin
            int m, jj;
            m  = int'($urandom_range(0, 3));
            jj = int'($urandom_range(RMIN, RMAX));
            run_msg(5'($urandom), 5'($urandom), 5'($urandom), 4'($urandom), jj, m, 1);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule